// File: doc/BRIEF.md
# Print Line Buffer Echo Sequencer

This block gathers one print line from a word-serial channel. A line is twelve rows of 72 bits, and each row is held as two 36-bit words, so the line fills a 24-word buffer. A start command selects binary or normal filling and turns the echo service on or off. A line starts only after a programmable start delay. After that, data slots are spaced by a short or a long inter-word delay. The channel places each word in a one-word holding register through a valid strobe. Each data slot takes the word that is in that register at the time.

In write mode the block only stores words. In echo mode it runs a fixed 46-slot schedule. Data slots alternate with echo slots. In an echo slot the block sends a derived row word back to the channel on a read port. Echo words are either AND combinations of digit rows or copies of the digit rows. When a line completes, the block pulses a done flag, waits a stop delay and then either starts the next line in the same mode (while the channel stays connected) or goes idle. A data slot that finds no fresh word sets a sticky I/O-check flag.

Top module: `print_line_echo_seq`

## Requirements
- R1: While reset is asserted, and right after it, the block is idle and all of its outputs are low: `wordReq`, `wrSlot`, `rdValid`, `lineDone`, `ioCheck` and `startBusy`.
- R2: `startValid` is accepted when the block is idle. The line begins START_DLY cycles after the accepting edge. The first data slot follows SHORT_DLY cycles later.
- R3: At the start of every line, the data buffer, the echo buffer and the holding register are cleared. Rows that the line never writes therefore read as zero.
- R4: Buffer word index 2r and 2r+1 hold the r-th row in the row order 9,8,...,1,0,11,12. A normal line (`startBinary`=0) fills indices 0 to 23, one per data slot, which is 24 slots. A binary line fills only indices 16 and 17 (row 1), which is 2 slots. `lineDone` is a one-cycle pulse in the cycle after the final slot.
- R5: In write mode, a word latched with `wrEor`=1 ends the line at the slot that takes it. In echo mode `wrEor` has no effect.
- R6: In echo mode (`startEcho`=1) the slots are numbered 0 to 45, starting at 0 for a normal line and at 16 for a binary line. Slots 18,19, 22,23, 26,27 and 30 to 45 are echo slots, and each produces a single `rdValid` pulse. All other slots are data slots, and each produces a single `wrSlot` pulse. Data slots store buffer indices in ascending order.
- R7: Echo words are sent in ascending echo index 0 to 21. Word 0 is buffer[2] AND buffer[10], and word 1 is buffer[3] AND buffer[11] (row 8 AND row 4). Words 2 and 3 are buffer[2],[3] ANDed with buffer[12],[13] (row 8 AND row 3). Word 4+i is buffer[i] for i from 0 to 17. The echo buffer is captured at echo slot 0.
- R8: A data slot that finds the holding register empty sets `ioCheck` and stores the stale register contents. `ioCheck` stays set until the next accepted start.
- R9: The gap from a slot to the next slot is SHORT_DLY cycles after an echo slot or after a data slot at an odd slot number, and LONG_DLY cycles after a data slot at an even slot number.
- R10: STOP_DLY cycles after `lineDone`, the block returns to line start in the same mode if `chanConnected` is high. Otherwise it becomes idle and accepts a new start.
- R11: A start command that arrives while a line, or its stop delay, is in progress is refused. `startBusy` pulses in the next cycle, and the running line is not disturbed.
- R12: `wordReq` is high only while the current slot is a data slot. Every `wrSlot` pulse is preceded by `wordReq` being high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command strobe |
| startBinary | input | 1 | Binary-mode flag of the command |
| startEcho | input | 1 | Echo-mode flag of the command |
| chanConnected | input | 1 | Channel still attached at line end |
| wrValid | input | 1 | Write word strobe |
| wrData | input | 36 | Write word |
| wrEor | input | 1 | End-of-record marker with the word |
| wordReq | output | 1 | Next slot wants a channel word |
| wrSlot | output | 1 | A data slot was taken |
| rdValid | output | 1 | Echo word strobe |
| rdData | output | 36 | Echo word |
| lineDone | output | 1 | Line complete pulse |
| ioCheck | output | 1 | Sticky missing-word flag |
| startBusy | output | 1 | Start refused pulse |

## Verification
The bench runs normal and binary lines in both modes. Comparing slot counts separates the two fill ranges and the two schedules. A binary echo line that follows a fully written normal echo line shows whether the buffers were cleared: if they were not, stale digit rows appear in the echo words. An early end-of-record is tried in both modes, which shows whether it is honoured in write mode and ignored in echo mode. A deliberately missing word exposes both the sticky flag and the stale store. Slot spacing is timed on every gap, so a swapped short and long delay shows up.

// File: rtl/plbes_pkg.sv
package plbes_pkg;
  localparam int WORD_W      = 36;
  localparam int ROW_COUNT   = 12;
  localparam int BUF_WORDS   = 2 * ROW_COUNT;
  localparam int DIGIT_WORDS = 18;
  localparam int ECHO_WORDS  = DIGIT_WORDS + 4;
  localparam int SLOT_COUNT  = BUF_WORDS + ECHO_WORDS;
  localparam int MIX_END     = DIGIT_WORDS + 2 * (BUF_WORDS - DIGIT_WORDS);
  localparam int IDX_W       = $clog2(BUF_WORDS);
  localparam int SLOT_W      = $clog2(SLOT_COUNT);
  // word positions of rows used by the echo words
  localparam int ROW8_POS    = 2;
  localparam int ROW4_POS    = 10;
  localparam int ROW3_POS    = 12;
  localparam int ROW1_POS    = 16;

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_PRINT = 2'd1,
    ST_ECHO  = 2'd2,
    ST_END   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic             isEcho;
    logic [IDX_W-1:0] idx;
  } slotMap_t;

  typedef struct packed {
    logic             clearAll;
    logic             storeWord;
    logic             buildEcho;
    logic             sendEcho;
    logic [IDX_W-1:0] idx;
  } dpStrobes_t;

  // echo-mode schedule: slot number -> data or echo word index
  function automatic slotMap_t mapSlot(input logic [SLOT_W-1:0] s);
    slotMap_t m;
    int v;
    int g;
    int r;
    v = int'(s);
    m.isEcho = 1'b0;
    m.idx = '0;
    if (v < DIGIT_WORDS) begin
      m.idx = IDX_W'(v);
    end else if (v < MIX_END) begin
      g = (v - DIGIT_WORDS) / 4;
      r = (v - DIGIT_WORDS) % 4;
      if (r < 2) begin
        m.isEcho = 1'b1;
        m.idx = IDX_W'(2 * g + r);
      end else begin
        m.idx = IDX_W'(DIGIT_WORDS + 2 * g + r - 2);
      end
    end else begin
      m.isEcho = 1'b1;
      m.idx = IDX_W'(v - BUF_WORDS);
    end
    return m;
  endfunction
endpackage

// File: rtl/plbes_ctrl.sv
module plbes_ctrl
  import plbes_pkg::*;
#(
  parameter int START_DLY = 55,
  parameter int STOP_DLY  = 55,
  parameter int SHORT_DLY = 3,
  parameter int LONG_DLY  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startBinary,
  input  logic       startEcho,
  input  logic       chanConnected,
  input  logic       latchValid,
  input  logic       latchEor,
  output dpStrobes_t strobes,
  output logic       wordReq,
  output logic       wrSlot,
  output logic       startBusy,
  output logic       lineDone,
  output logic       ioCheck,
  output logic       lineActive
);
  localparam int MAX_A  = (START_DLY > STOP_DLY) ? START_DLY : STOP_DLY;
  localparam int MAX_B  = (SHORT_DLY > LONG_DLY) ? SHORT_DLY : LONG_DLY;
  localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_D + 1);
  localparam logic [TMR_W-1:0] LD_START = TMR_W'(START_DLY - 1);
  localparam logic [TMR_W-1:0] LD_STOP  = TMR_W'(STOP_DLY - 1);
  localparam logic [TMR_W-1:0] LD_SHORT = TMR_W'(SHORT_DLY - 1);
  localparam logic [TMR_W-1:0] LD_LONG  = TMR_W'(LONG_DLY - 1);
  localparam logic [SLOT_W-1:0] SLOT_BIN   = SLOT_W'(ROW1_POS);
  localparam logic [SLOT_W-1:0] LAST_BIN   = SLOT_W'(ROW1_POS + 1);
  localparam logic [SLOT_W-1:0] LAST_NORM  = SLOT_W'(BUF_WORDS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOT_COUNT - 1);

  seqState_t         state;
  logic              active;
  logic              binMode;
  logic              echoMode;
  logic [SLOT_W-1:0] slot;
  logic [TMR_W-1:0]  timer;
  logic              tick;
  logic              startTake;
  slotMap_t          curMap;
  logic [SLOT_W-1:0] lastPrint;

  assign tick       = active && (timer == '0);
  assign startTake  = startValid && !active;
  assign curMap     = mapSlot(slot);
  assign lastPrint  = binMode ? LAST_BIN : LAST_NORM;
  assign lineActive = active;
  assign wordReq    = active && ((state == ST_PRINT) ||
                                 ((state == ST_ECHO) && !curMap.isEcho));

  always_comb begin
    strobes = '0;
    strobes.idx = curMap.idx;
    if (tick) begin
      case (state)
        ST_INIT:  strobes.clearAll = 1'b1;
        ST_PRINT: begin
          strobes.storeWord = 1'b1;
          strobes.idx = slot[IDX_W-1:0];
        end
        ST_ECHO: begin
          if (curMap.isEcho) begin
            strobes.sendEcho  = 1'b1;
            strobes.buildEcho = (curMap.idx == '0);
          end else begin
            strobes.storeWord = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_INIT;
      active    <= 1'b0;
      binMode   <= 1'b0;
      echoMode  <= 1'b0;
      slot      <= '0;
      timer     <= '0;
      ioCheck   <= 1'b0;
      lineDone  <= 1'b0;
      wrSlot    <= 1'b0;
      startBusy <= 1'b0;
    end else begin
      lineDone  <= 1'b0;
      wrSlot    <= 1'b0;
      startBusy <= startValid && active;
      if (startTake) begin
        active   <= 1'b1;
        binMode  <= startBinary;
        echoMode <= startEcho;
        state    <= ST_INIT;
        timer    <= LD_START;
        ioCheck  <= 1'b0;
      end else if (active) begin
        if (timer != '0) begin
          timer <= timer - 1'b1;
        end else begin
          case (state)
            ST_INIT: begin
              slot  <= binMode ? SLOT_BIN : '0;
              state <= echoMode ? ST_ECHO : ST_PRINT;
              timer <= LD_SHORT;
            end
            ST_PRINT: begin
              wrSlot <= 1'b1;
              if (!latchValid) ioCheck <= 1'b1;
              if ((latchValid && latchEor) || (slot == lastPrint)) begin
                state    <= ST_END;
                timer    <= LD_STOP;
                lineDone <= 1'b1;
              end else begin
                slot  <= slot + 1'b1;
                timer <= slot[0] ? LD_SHORT : LD_LONG;
              end
            end
            ST_ECHO: begin
              if (!curMap.isEcho) begin
                wrSlot <= 1'b1;
                if (!latchValid) ioCheck <= 1'b1;
              end
              if (slot == LAST_SLOT) begin
                state    <= ST_END;
                timer    <= LD_STOP;
                lineDone <= 1'b1;
              end else begin
                slot  <= slot + 1'b1;
                timer <= (curMap.isEcho || slot[0]) ? LD_SHORT : LD_LONG;
              end
            end
            default: begin
              state <= ST_INIT;
              if (!chanConnected) active <= 1'b0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/plbes_datapath.sv
module plbes_datapath
  import plbes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrEor,
  output logic              latchValid,
  output logic              latchEor,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] dataBuf  [BUF_WORDS];
  logic [WORD_W-1:0] echoBuf  [ECHO_WORDS];
  logic [WORD_W-1:0] echoNext [ECHO_WORDS];
  logic [WORD_W-1:0] latchData;

  // derived echo rows: two row-pair ANDs, then the digit rows
  generate
    for (genvar h = 0; h < 2; h++) begin : g_and
      assign echoNext[h]     = dataBuf[ROW8_POS + h] & dataBuf[ROW4_POS + h];
      assign echoNext[2 + h] = dataBuf[ROW8_POS + h] & dataBuf[ROW3_POS + h];
    end
    for (genvar d = 0; d < DIGIT_WORDS; d++) begin : g_copy
      assign echoNext[4 + d] = dataBuf[d];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchValid <= 1'b0;
      latchEor   <= 1'b0;
      latchData  <= '0;
    end else begin
      if (strobes.clearAll) begin
        latchData <= '0;
        latchEor  <= 1'b0;
      end
      if (strobes.clearAll || strobes.storeWord) latchValid <= 1'b0;
      if (wrValid) begin
        latchValid <= 1'b1;
        latchData  <= wrData;
        latchEor   <= wrEor;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      for (int i = 0; i < BUF_WORDS; i++) dataBuf[i] <= '0;
      for (int j = 0; j < ECHO_WORDS; j++) echoBuf[j] <= '0;
    end else begin
      if (strobes.storeWord) dataBuf[strobes.idx] <= latchData;
      if (strobes.buildEcho) begin
        for (int j = 0; j < ECHO_WORDS; j++) echoBuf[j] <= echoNext[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.sendEcho;
      if (strobes.sendEcho) begin
        rdData <= strobes.buildEcho ? echoNext[strobes.idx] : echoBuf[strobes.idx];
      end
    end
  end
endmodule

// File: rtl/print_line_echo_seq.sv
module print_line_echo_seq
  import plbes_pkg::*;
#(
  parameter int START_DLY = 55,
  parameter int STOP_DLY  = 55,
  parameter int SHORT_DLY = 3,
  parameter int LONG_DLY  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startBinary,
  input  logic              startEcho,
  input  logic              chanConnected,
  input  logic              wrValid,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrEor,
  output logic              wordReq,
  output logic              wrSlot,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData,
  output logic              lineDone,
  output logic              ioCheck,
  output logic              startBusy
);
  dpStrobes_t strobes;
  logic       latchValid;
  logic       latchEor;
  logic       lineActive;

  plbes_ctrl #(
    .START_DLY(START_DLY), .STOP_DLY(STOP_DLY),
    .SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startBinary(startBinary), .startEcho(startEcho),
    .chanConnected(chanConnected),
    .latchValid(latchValid), .latchEor(latchEor),
    .strobes(strobes), .wordReq(wordReq), .wrSlot(wrSlot),
    .startBusy(startBusy), .lineDone(lineDone), .ioCheck(ioCheck),
    .lineActive(lineActive)
  );

  plbes_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrValid(wrValid), .wrData(wrData), .wrEor(wrEor),
    .latchValid(latchValid), .latchEor(latchEor),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/print_line_echo_seq_checker.sv
module print_line_echo_seq_checker (
  input logic clk,
  input logic rstN,
  input logic startValid,
  input logic startBusy,
  input logic wordReq,
  input logic wrSlot,
  input logic rdValid,
  input logic lineDone,
  input logic ioCheck,
  input logic lineActive
);
  assert_slot_kind_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSlot && rdValid));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

  assert_io_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ioCheck && !(startValid && !lineActive)) |=> ioCheck);

  assert_busy_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && lineActive) |=> startBusy);

  assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> !startBusy);

  assert_req_before_slot_R12: assert property (@(posedge clk) disable iff (!rstN)
    wrSlot |-> $past(wordReq));
endmodule

bind print_line_echo_seq print_line_echo_seq_checker i_checker (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startBusy(startBusy),
  .wordReq(wordReq), .wrSlot(wrSlot), .rdValid(rdValid),
  .lineDone(lineDone), .ioCheck(ioCheck), .lineActive(lineActive)
);

// File: tb/test_print_line_echo_seq.sv
`timescale 1ns/100ps
module test_print_line_echo_seq;
  localparam int T_START = 4;
  localparam int T_STOP  = 5;
  localparam int T_SHORT = 2;
  localparam int T_LONG  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0, startBinary = 1'b0, startEcho = 1'b0;
  logic chanConnected = 1'b0, wrValid = 1'b0, wrEor = 1'b0;
  logic [35:0] wrData = '0;
  logic wordReq, wrSlot, rdValid, lineDone, ioCheck, startBusy;
  logic [35:0] rdData;

  always #2.5 clk = ~clk;

  print_line_echo_seq #(
    .START_DLY(T_START), .STOP_DLY(T_STOP), .SHORT_DLY(T_SHORT), .LONG_DLY(T_LONG)
  ) i_print_line_echo_seq (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startBinary(startBinary),
    .startEcho(startEcho), .chanConnected(chanConnected), .wrValid(wrValid),
    .wrData(wrData), .wrEor(wrEor), .wordReq(wordReq), .wrSlot(wrSlot),
    .rdValid(rdValid), .rdData(rdData), .lineDone(lineDone), .ioCheck(ioCheck),
    .startBusy(startBusy)
  );

  int total = 0, bad = 0;
  logic [35:0] expBuf [24];
  logic [35:0] lastLatch;
  logic [35:0] gotEcho [22];
  int nSlots, nEcho, busySeen, gapBad, startLat;
  bit wdFail = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input int k, input int seed);
    return 36'((64'(k + 3) * 64'h9E3779B97F) ^ (64'(seed) << 9) ^ (64'(seed * k) << 21));
  endfunction

  function automatic bit echoSlot(input int s);
    return (s >= 18 && s < 30 && ((s - 18) % 4) < 2) || s >= 30;
  endfunction

  function automatic int gapAfter(input int s, input bit echo);
    if (echo && echoSlot(s)) return T_SHORT;
    return (s % 2 == 1) ? T_SHORT : T_LONG;
  endfunction

  task automatic runLine(input bit bin, input bit echo, input bit doStart,
                         input int eorAt, input int skipAt, input int busyAt, input int seed);
    int n = 0;
    int wIdx = 0;
    int evCount = 0;
    int prevN = 0;
    int first;
    bit pending = 1'b0;
    bit busyDone = 1'b0;
    first = bin ? 16 : 0;
    nSlots = 0; nEcho = 0; busySeen = 0; gapBad = 0; startLat = -1;
    for (int i = 0; i < 24; i++) expBuf[i] = '0;
    lastLatch = '0;
    if (doStart) begin
      @(negedge clk);
      startValid = 1'b1; startBinary = bin; startEcho = echo;
    end
    forever begin
      @(negedge clk);
      n++;
      startValid = 1'b0; wrValid = 1'b0; wrEor = 1'b0;
      if (startBusy) busySeen++;
      if (wrSlot || rdValid) begin
        if (wrSlot) begin nSlots++; pending = 1'b0; end
        if (rdValid) begin
          if (nEcho < 22) gotEcho[nEcho] = rdData;
          nEcho++;
        end
        if (evCount == 0) startLat = n;
        else if (n - prevN != gapAfter(first + evCount - 1, echo)) gapBad++;
        prevN = n;
        evCount++;
      end
      if (lineDone) break;
      if (n > 3000) begin wdFail = 1'b1; break; end
      if (busyAt == evCount && !busyDone) begin
        startValid = 1'b1; startBinary = !bin; startEcho = !echo; busyDone = 1'b1;
      end
      if (wordReq && !pending) begin
        if (wIdx == skipAt) begin
          expBuf[first + wIdx] = lastLatch;
        end else begin
          wrData = pat(wIdx, seed);
          wrValid = 1'b1;
          wrEor = (wIdx == eorAt);
          expBuf[first + wIdx] = wrData;
          lastLatch = wrData;
        end
        pending = 1'b1;
        wIdx++;
      end
    end
    check(!wdFail, "line watchdog", longint'(n), 0);
  endtask

  task automatic settle();
    repeat (T_STOP + 2) @(negedge clk);
  endtask

  task automatic compareEcho(input string tag);
    logic [35:0] e [22];
    e[0] = expBuf[2] & expBuf[10];
    e[1] = expBuf[3] & expBuf[11];
    e[2] = expBuf[2] & expBuf[12];
    e[3] = expBuf[3] & expBuf[13];
    for (int i = 0; i < 18; i++) e[4 + i] = expBuf[i];
    for (int j = 0; j < 22; j++)
      check(gotEcho[j] === e[j], $sformatf("%s echo word %0d", tag, j), gotEcho[j], e[j]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({wordReq, wrSlot, rdValid, lineDone, ioCheck, startBusy} === 6'b0,
          "R1 reset outputs", {wordReq, wrSlot, rdValid, lineDone, ioCheck, startBusy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({wordReq, wrSlot, rdValid, lineDone, ioCheck, startBusy} === 6'b0,
          "R1 idle after reset", {wordReq, wrSlot, rdValid, lineDone, ioCheck, startBusy}, 0);

    // normal write line
    runLine(1'b0, 1'b0, 1'b1, -1, -1, -1, 1);
    check(nSlots == 24, "R4 normal slot count", nSlots, 24);
    check(nEcho == 0, "R6 no echo in write mode", nEcho, 0);
    check(startLat == T_START + T_SHORT + 1, "R2 start latency", startLat, T_START + T_SHORT + 1);
    check(gapBad == 0, "R9 write-mode gaps", gapBad, 0);
    check(ioCheck == 1'b0, "R8 no io check", ioCheck, 0);
    settle();
    check(wordReq == 1'b0, "R10 idle when disconnected", wordReq, 0);

    // binary write line
    runLine(1'b1, 1'b0, 1'b1, -1, -1, -1, 2);
    check(nSlots == 2, "R4 binary slot count", nSlots, 2);
    check(busySeen == 0, "R10 start accepted after idle", busySeen, 0);
    settle();

    // early end of record in write mode
    runLine(1'b0, 1'b0, 1'b1, 7, -1, -1, 3);
    check(nSlots == 8, "R5 eor ends write line", nSlots, 8);
    settle();

    // normal echo line
    runLine(1'b0, 1'b1, 1'b1, -1, -1, -1, 4);
    check(nSlots == 24, "R6 echo data slots", nSlots, 24);
    check(nEcho == 22, "R6 echo slots", nEcho, 22);
    check(gapBad == 0, "R9 echo-mode gaps", gapBad, 0);
    compareEcho("R7 normal");
    settle();

    // binary echo line after a full line: unwritten rows read zero
    runLine(1'b1, 1'b1, 1'b1, -1, -1, -1, 5);
    check(nSlots == 8, "R6 binary echo data slots", nSlots, 8);
    check(nEcho == 22, "R6 binary echo slots", nEcho, 22);
    check(gapBad == 0, "R9 binary echo gaps", gapBad, 0);
    compareEcho("R3 cleared");
    settle();

    // eor ignored in echo mode
    runLine(1'b0, 1'b1, 1'b1, 3, -1, -1, 6);
    check(nSlots == 24, "R5 eor ignored in echo", nSlots, 24);
    check(nEcho == 22, "R5 echo count with eor", nEcho, 22);
    settle();

    // missing word
    runLine(1'b0, 1'b1, 1'b1, -1, 5, -1, 7);
    check(ioCheck == 1'b1, "R8 io check set", ioCheck, 1);
    check(gotEcho[9] === pat(4, 7), "R8 stale word stored", gotEcho[9], pat(4, 7));
    compareEcho("R8 skip");
    settle();
    check(ioCheck == 1'b1, "R8 io check sticky", ioCheck, 1);

    runLine(1'b0, 1'b0, 1'b1, -1, -1, -1, 8);
    check(ioCheck == 1'b0, "R8 cleared by start", ioCheck, 0);
    settle();

    // refused start during a line
    runLine(1'b0, 1'b0, 1'b1, -1, -1, 3, 9);
    check(busySeen == 1, "R11 busy pulse", busySeen, 1);
    check(nSlots == 24, "R11 line undisturbed", nSlots, 24);
    check(gapBad == 0, "R11 timing undisturbed", gapBad, 0);
    settle();

    // reconnect: next line starts by itself
    chanConnected = 1'b1;
    runLine(1'b1, 1'b0, 1'b1, -1, -1, -1, 10);
    runLine(1'b1, 1'b0, 1'b0, -1, -1, -1, 11);
    chanConnected = 1'b0;
    check(nSlots == 2, "R10 reconnect line slots", nSlots, 2);
    settle();
    check(wordReq == 1'b0, "R12 no request when idle", wordReq, 0);
    runLine(1'b1, 1'b0, 1'b1, -1, -1, -1, 12);
    check(busySeen == 0 && nSlots == 2, "R10 idle after disconnect", busySeen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "global watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule